// File: doc/BRIEF.md
# Password-Protected Banked GPIO Register File

This block keeps the output levels and per-pin configuration of a set of 32-pin GPIO banks behind a simple synchronous register bus. Software drives outputs either by loading a whole bank word or by writing one-hot style set and clear words. It reads either the pad levels or the driven levels of a bank. Each pin has its own configuration word. Bit 0 of that word picks the pin direction, and the remaining bits are held for neighbouring logic such as edge detection.

Every bank is guarded by a write lock. A bank can only be unlocked or relocked by a two-step sequence: first the magic key 0x00A5A501 goes to the global key register, and then a lock code goes to that bank's lock register as the very next bus write. While a bank is locked, the bus cannot change its outputs or configuration. Reads are always allowed. The bus uses a single request strobe with a write flag. Read data appears one cycle after the request.

Top module: `gpio_lockbank`

## Requirements
- R1: After reset every bank reads as locked (lock register returns 0xFFFFFFFF), every configuration word is 1 (input), all pin outputs are 0, all pad enables are 0, and the key is not armed.
- R2: A write of 0x00A5A501 to byte address 0x520 arms the key for the next bus write only.
- R3: The lock register of bank b sits at 0x500 + 4·b. While the key is armed, writing 0x00000000 to it unlocks the bank and writing 0xFFFFFFFF locks it. Any other value, or any write while the key is not armed, leaves the lock unchanged. Reading it returns all ones when the bank is locked and zero when it is unlocked.
- R4: A write of a wrong value to 0x520, or a write to any other address, disarms the key. Reads do not disarm it.
- R5: While bank b is locked, writes to its output, set, clear and configuration registers change nothing.
- R6: The output register of bank b at 0x00 + 4·b reads back the driven levels. A write to it loads all 32 levels when the bank is unlocked.
- R7: A write to 0x40 + 4·b sets, and a write to 0x60 + 4·b clears, each output bit whose data bit is 1. Bits with a 0 keep their value. Both registers read as 0.
- R8: A read of 0x20 + 4·b returns the pad input levels of bank b as sampled in the request cycle.
- R9: The configuration word of pin p sits at 0x100 + 4·p and stores the low CTRL_W data bits. Bit 0 = 1 makes the pin an input and 0 makes it an output. The pad enable of the pin is the inverse of bit 0, and its pad output is its output bit.
- R10: Read data is valid in the cycle after a read request and is 0 in every other cycle. Misaligned addresses, unmapped addresses and indexes beyond the configured banks or pins read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| pin_in | input | NUM_BANKS·32 | Pad input levels |
| pin_out | output | NUM_BANKS·32 | Pad output levels |
| pin_oe | output | NUM_BANKS·32 | Pad output enables |

## Verification
The bench targets the unlock handshake at its edges. It tries a lock-code write with no key, a key with the wrong value, an unrelated write between key and code, a read between key and code, and lock values that are neither code. A design that kept the key armed too long would let any later write unlock a bank. A design that cleared the key on reads would refuse a legal sequence. Writes to every register of a locked bank are checked against unchanged pads, because a missed gate would quietly change them. Out-of-range bank indexes, misaligned and unmapped addresses, and a last-pin configuration word are also checked. A decode that wraps would alias into real registers.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
    localparam int unsigned BANK_W = 32;
    localparam int unsigned IDX_W  = 8;

    localparam logic [31:0] KEY_MAGIC   = 32'h00A5_A501;
    localparam logic [31:0] CODE_OPEN   = 32'h0000_0000;
    localparam logic [31:0] CODE_CLOSE  = 32'hFFFF_FFFF;

    localparam logic [11:0] ADDR_KEY    = 12'h520;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_OUT,
        RG_IN,
        RG_SET,
        RG_CLR,
        RG_CFG,
        RG_LOCK,
        RG_KEY
    } region_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_lock_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned NUM_PINS  = NUM_BANKS * BANK_W
) (
    input  logic [11:0]      addr,
    output region_e          region,
    output logic [IDX_W-1:0] idx
);
    localparam logic [3:0] BANK_LIM = 4'(NUM_BANKS);
    localparam logic [9:0] PIN_LIM  = 10'(NUM_PINS);

    logic [9:0] cfg_off;
    logic       bank_ok;

    always_comb begin
        cfg_off = addr[11:2] - 10'd64;
        bank_ok = {1'b0, addr[4:2]} < BANK_LIM;
        region  = RG_NONE;
        idx     = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr[11:5] == 7'h00 && bank_ok) begin
                region = RG_OUT;  idx = IDX_W'(addr[4:2]);
            end else if (addr[11:5] == 7'h01 && bank_ok) begin
                region = RG_IN;   idx = IDX_W'(addr[4:2]);
            end else if (addr[11:5] == 7'h02 && bank_ok) begin
                region = RG_SET;  idx = IDX_W'(addr[4:2]);
            end else if (addr[11:5] == 7'h03 && bank_ok) begin
                region = RG_CLR;  idx = IDX_W'(addr[4:2]);
            end else if (addr >= 12'h100 && addr < 12'h500 && cfg_off < PIN_LIM) begin
                region = RG_CFG;  idx = cfg_off[IDX_W-1:0];
            end else if (addr[11:5] == 7'h28 && bank_ok) begin
                region = RG_LOCK; idx = IDX_W'(addr[4:2]);
            end else if (addr == ADDR_KEY) begin
                region = RG_KEY;
            end
        end
    end
endmodule

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
    import gpio_lock_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  region_e              region,
    input  logic [IDX_W-1:0]     idx,
    input  logic [31:0]          wdata,
    output logic [NUM_BANKS-1:0] locked,
    output logic                 armed
);
    typedef struct packed {
        logic                 armed;
        logic [NUM_BANKS-1:0] locked;
    } lock_state_t;

    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stb) begin
            st_d.armed = (region == RG_KEY) && (wdata == KEY_MAGIC);
            if (st_q.armed && region == RG_LOCK) begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (idx == IDX_W'(b)) begin
                        if (wdata == CODE_OPEN)       st_d.locked[b] = 1'b0;
                        else if (wdata == CODE_CLOSE) st_d.locked[b] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.armed  <= 1'b0;
            st_q.locked <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.locked;
    assign armed  = st_q.armed;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_lock_pkg::*;
#(
    parameter int unsigned CTRL_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     out_we,
    input  logic                     set_we,
    input  logic                     clr_we,
    input  logic [BANK_W-1:0]        cfg_we,
    input  logic [31:0]              wdata,
    output logic [BANK_W-1:0]        out_o,
    output logic [BANK_W*CTRL_W-1:0] cfg_o
);
    typedef struct packed {
        logic [BANK_W-1:0]             out;
        logic [BANK_W-1:0][CTRL_W-1:0] cfg;
    } bank_state_t;

    bank_state_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (out_we) bk_d.out = wdata[BANK_W-1:0];
        if (set_we) bk_d.out = bk_d.out | wdata[BANK_W-1:0];
        if (clr_we) bk_d.out = bk_d.out & ~wdata[BANK_W-1:0];
        for (int p = 0; p < BANK_W; p++) begin
            if (cfg_we[p]) bk_d.cfg[p] = wdata[CTRL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q.out <= '0;
            for (int p = 0; p < BANK_W; p++) bk_q.cfg[p] <= CTRL_W'(1);
        end else begin
            bk_q <= bk_d;
        end
    end

    assign out_o = bk_q.out;
    assign cfg_o = bk_q.cfg;
endmodule

// File: rtl/gpio_lockbank.sv
module gpio_lockbank
    import gpio_lock_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned CTRL_W    = 9,
    localparam int unsigned NUM_PINS = NUM_BANKS * BANK_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [11:0]         bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);
    localparam int unsigned CFG_BITS = NUM_PINS * CTRL_W;

    region_e              region;
    logic [IDX_W-1:0]     idx;
    logic                 wr_stb, rd_stb;
    logic [NUM_BANKS-1:0] bank_locked;
    logic                 pwd_armed;
    logic [CFG_BITS-1:0]  all_cfg;
    logic [31:0]          rd_d, rd_q;

    assign wr_stb = bus_valid & bus_write;
    assign rd_stb = bus_valid & ~bus_write;

    gpio_addr_dec #(.NUM_BANKS(NUM_BANKS), .NUM_PINS(NUM_PINS)) u_dec (
        .addr   (bus_addr),
        .region (region),
        .idx    (idx)
    );

    gpio_lock_ctrl #(.NUM_BANKS(NUM_BANKS)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .region (region),
        .idx    (idx),
        .wdata  (bus_wdata),
        .locked (bank_locked),
        .armed  (pwd_armed)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic              open_wr, bank_hit, cfg_hit;
        logic [BANK_W-1:0] cfg_we;

        assign open_wr  = wr_stb & ~bank_locked[b];
        assign bank_hit = open_wr && idx == IDX_W'(b);
        assign cfg_hit  = open_wr && region == RG_CFG && idx[IDX_W-1:5] == (IDX_W-5)'(b);

        for (genvar p = 0; p < BANK_W; p++) begin : g_pin
            assign cfg_we[p] = cfg_hit && idx[4:0] == 5'(p);
            assign pin_oe[b*BANK_W+p] = ~all_cfg[(b*BANK_W+p)*CTRL_W];
        end

        gpio_bank_regs #(.CTRL_W(CTRL_W)) u_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .out_we (bank_hit && region == RG_OUT),
            .set_we (bank_hit && region == RG_SET),
            .clr_we (bank_hit && region == RG_CLR),
            .cfg_we (cfg_we),
            .wdata  (bus_wdata),
            .out_o  (pin_out[b*BANK_W +: BANK_W]),
            .cfg_o  (all_cfg[b*BANK_W*CTRL_W +: BANK_W*CTRL_W])
        );
    end

    always_comb begin
        rd_d = '0;
        if (rd_stb) begin
            case (region)
                RG_OUT: for (int b = 0; b < NUM_BANKS; b++)
                    if (idx == IDX_W'(b)) rd_d = pin_out[b*BANK_W +: BANK_W];
                RG_IN: for (int b = 0; b < NUM_BANKS; b++)
                    if (idx == IDX_W'(b)) rd_d = pin_in[b*BANK_W +: BANK_W];
                RG_LOCK: for (int b = 0; b < NUM_BANKS; b++)
                    if (idx == IDX_W'(b)) rd_d = {32{bank_locked[b]}};
                RG_CFG: for (int p = 0; p < NUM_PINS; p++)
                    if (idx == IDX_W'(p)) rd_d = 32'(all_cfg[p*CTRL_W +: CTRL_W]);
                default: rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q;
endmodule

// File: rtl/gpio_lockbank_chk.sv
module gpio_lockbank_chk
    import gpio_lock_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    localparam int unsigned NUM_PINS = NUM_BANKS * BANK_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [11:0]          bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_PINS-1:0]  pin_out,
    input logic [NUM_PINS-1:0]  pin_oe,
    input logic [NUM_BANKS-1:0] locked,
    input logic                 armed
);
    // R2
    key_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(bus_valid && bus_write && bus_addr == ADDR_KEY && bus_wdata == KEY_MAGIC));

    // R4
    key_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(armed && bus_valid && bus_write && !(bus_addr == ADDR_KEY && bus_wdata == KEY_MAGIC)) |-> !armed);

    // R3
    lock_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(locked) |-> $past(armed && bus_valid && bus_write));

    // R10
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(bus_valid && !bus_write)) |-> bus_rdata == 32'h0);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hold
        // R5
        locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(locked[b]) |-> ($stable(pin_out[b*BANK_W +: BANK_W]) && $stable(pin_oe[b*BANK_W +: BANK_W])));
    end
endmodule

bind gpio_lockbank gpio_lockbank_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .locked    (bank_locked),
    .armed     (pwd_armed)
);

// File: tb/sim_gpio_lockbank.sv
module sim_gpio_lockbank;
    localparam int NB = 2;
    localparam int CW = 9;
    localparam int NP = NB * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;

    logic [31:0]   m_out [NB];
    logic [CW-1:0] m_cfg [NP];
    bit            m_lock [NB];
    bit            m_armed;

    always #10 clk = ~clk;

    gpio_lockbank #(.NUM_BANKS(NB), .CTRL_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_armed = 0;
        for (int b = 0; b < NB; b++) begin m_out[b] = '0; m_lock[b] = 1; end
        for (int p = 0; p < NP; p++) m_cfg[p] = CW'(1);
    endfunction

    function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
        bit was = m_armed;
        int k = int'(a) / 4;
        m_armed = (a == 12'h520) && (d == 32'h00A5A501);
        if (a[1:0] != 2'b00) return;
        if (a >= 12'h500 && a < 12'h520 && (k - 320) < NB) begin
            if (was && d == 32'h0) m_lock[k-320] = 0;
            else if (was && d == 32'hFFFFFFFF) m_lock[k-320] = 1;
        end else if (a < 12'h20 && k < NB) begin
            if (!m_lock[k]) m_out[k] = d;
        end else if (a >= 12'h40 && a < 12'h60 && (k - 16) < NB) begin
            if (!m_lock[k-16]) m_out[k-16] = m_out[k-16] | d;
        end else if (a >= 12'h60 && a < 12'h80 && (k - 24) < NB) begin
            if (!m_lock[k-24]) m_out[k-24] = m_out[k-24] & ~d;
        end else if (a >= 12'h100 && a < 12'h500 && (k - 64) < NP) begin
            if (!m_lock[(k-64)/32]) m_cfg[k-64] = d[CW-1:0];
        end
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int k = int'(a) / 4;
        if (a[1:0] != 2'b00) return '0;
        if (a < 12'h20 && k < NB) return m_out[k];
        if (a >= 12'h20 && a < 12'h40 && (k - 8) < NB) return pin_in[(k-8)*32 +: 32];
        if (a >= 12'h100 && a < 12'h500 && (k - 64) < NP) return 32'(m_cfg[k-64]);
        if (a >= 12'h500 && a < 12'h520 && (k - 320) < NB) return {32{m_lock[k-320]}};
        return '0;
    endfunction

    task automatic check_pins(input string tag);
        logic [NP-1:0] eo, ee;
        for (int b = 0; b < NB; b++) eo[b*32 +: 32] = m_out[b];
        for (int p = 0; p < NP; p++) ee[p] = ~m_cfg[p][0];
        check({{(64-NP){1'b0}}, pin_out}, {{(64-NP){1'b0}}, eo}, {tag, " pin_out"});
        check({{(64-NP){1'b0}}, pin_oe},  {{(64-NP){1'b0}}, ee}, {tag, " pin_oe"});
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
        model_write(a, d);
    endtask

    task automatic bus_rd(input logic [11:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        e = model_read(a);
        @(negedge clk);
        bus_valid = 0;
        check(64'(bus_rdata), 64'(e), tag);
    endtask

    task automatic unlock(input int b);
        bus_wr(12'h520, 32'h00A5A501);
        bus_wr(12'(12'h500 + 4 * b), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errs++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check_pins("R1");
        bus_rd(12'h500, "R1 bank0 locked");
        bus_rd(12'h504, "R1 bank1 locked");
        bus_rd(12'h114, "R1 cfg pin5");
        bus_rd(12'h1FC, "R1 cfg last pin");

        // R5 locked bank ignores writes
        bus_wr(12'h040, 32'hFFFF_FFFF);
        bus_wr(12'h000, 32'h1234_5678);
        bus_wr(12'h100, 32'h0);
        check_pins("R5 locked writes");

        // R3 lock write without key
        bus_wr(12'h500, 32'h0);
        bus_rd(12'h500, "R3 no key");

        // R4 wrong key value
        bus_wr(12'h520, 32'h00A5A500);
        bus_wr(12'h500, 32'h0);
        bus_rd(12'h500, "R4 wrong key");

        // R4 intervening write disarms
        bus_wr(12'h520, 32'h00A5A501);
        bus_wr(12'h084, 32'h0);
        bus_wr(12'h500, 32'h0);
        bus_rd(12'h500, "R4 intervening write");

        // R3 other lock value ignored
        bus_wr(12'h520, 32'h00A5A501);
        bus_wr(12'h500, 32'h0000_1234);
        bus_rd(12'h500, "R3 bad code");

        // R2 key then read then code still unlocks (R4: reads keep key)
        bus_wr(12'h520, 32'h00A5A501);
        bus_rd(12'h520, "R2 key reads zero");
        bus_wr(12'h500, 32'h0);
        bus_rd(12'h500, "R4 read keeps key");
        bus_rd(12'h504, "R3 other bank untouched");

        // R9 configuration and pad enable
        bus_wr(12'h10C, 32'h0000_01F0);
        bus_rd(12'h10C, "R9 cfg readback");
        check_pins("R9 pin3 output");

        // R7 set / clear, R6 load
        bus_wr(12'h040, 32'h0000_00F0);
        check_pins("R7 set");
        bus_wr(12'h060, 32'h0000_0030);
        check_pins("R7 clear");
        bus_rd(12'h040, "R7 set reads zero");
        bus_wr(12'h000, 32'hDEAD_BEEF);
        bus_rd(12'h000, "R6 load readback");
        check_pins("R6 pins");

        // R8 input status
        pin_in = 64'hA5A5_0F0F_1234_8001;
        bus_rd(12'h020, "R8 bank0 in");
        bus_rd(12'h024, "R8 bank1 in");
        pin_in = 64'h0;
        bus_rd(12'h024, "R8 bank1 zero");

        // R10 idle data, unmapped, misaligned, out of range
        @(negedge clk);
        check(64'(bus_rdata), 64'h0, "R10 idle zero");
        bus_rd(12'h008, "R10 bank2 out");
        bus_rd(12'h002, "R10 misaligned");
        bus_rd(12'h600, "R10 unmapped");
        bus_rd(12'h200, "R10 pin beyond range");
        bus_wr(12'h008, 32'hFFFF_FFFF);
        bus_wr(12'h001, 32'h0);
        check_pins("R10 dead writes");

        // R3 relock and R5 after relock
        bus_wr(12'h520, 32'h00A5A501);
        bus_wr(12'h500, 32'hFFFF_FFFF);
        bus_rd(12'h500, "R3 relock");
        bus_wr(12'h060, 32'hFFFF_FFFF);
        bus_wr(12'h10C, 32'h1);
        check_pins("R5 relocked");

        // R9 bank1 pin 63 configuration
        unlock(1);
        bus_wr(12'h1FC, 32'h0000_0002);
        bus_wr(12'h044, 32'h8000_0000);
        check_pins("R9 bank1 last pin");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op = int'($urandom % 7);
            int b  = int'($urandom % NB);
            logic [31:0] r = $urandom;
            pin_in = {$urandom, $urandom};
            case (op)
                0: begin
                    bus_wr(12'h520, ($urandom % 4 != 0) ? 32'h00A5A501 : r);
                    bus_wr(12'(12'h500 + 4 * b),
                           ($urandom % 2 != 0) ? 32'h0 : (($urandom % 3 != 0) ? 32'hFFFFFFFF : r));
                end
                1: bus_wr(12'(4 * b), r);
                2: bus_wr(12'(12'h040 + 4 * b), r);
                3: bus_wr(12'(12'h060 + 4 * b), r);
                4: bus_wr(12'(12'h100 + 4 * ($urandom % NP)), r);
                5: bus_rd(12'(4 * ($urandom % 328)), "R6 R8 R9 random read");
                default: bus_rd(12'(12'h500 + 4 * b), "R3 random lock read");
            endcase
            check_pins("R5 R7 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule